// File: doc/BRIEF.md
# Plug-and-Play Card Control State Machine

This block is the per-card control logic of a plug-and-play expansion card on an ISA-style I/O bus. It watches three kinds of bus cycle: a write to the fixed address port (0x279), which loads an internal register-select latch; a write to the fixed write-data port (0xA79), which writes the latched register; and a read at the card's relocatable read-data port, which returns the latched register. Inside it keeps the card state (wait-for-key, sleep, isolation, configure), the card select number, the selected logical device and the read-data-port address, and for each logical device an activate bit, a two-bit I/O range check field and a small bank of configuration bytes.

The unlock-key detector and the serial isolation datapath live outside. They report through two single-cycle pulses: `key_ok` (the key sequence was seen) and `isolation_lost` (the card lost a serial isolation round). Resource ROM storage is not part of this block; its wake-time index reset is given out as the `index_clr` pulse.

Read responses form a one-way stream: each read strobe yields exactly one `rd_valid` beat with `rd_data` one cycle later. The stream has no ready signal and the bus cannot stall, so the consumer must take every beat on the cycle it appears.

Top module: `pnp_card_ctrl`

## Requirements
- R1: After reset the state is wait-for-key (code 0), the card select number, logical device number and read-port address are 0, and every activate bit, range check field and configuration byte is 0.
- R2: In wait-for-key a `key_ok` pulse moves the card to sleep (code 1); in that state every data-port write has no effect, and `key_ok` in any other state is ignored.
- R3: An I/O write at address 0x279 loads the register-select latch; an I/O write at 0xA79 writes the latched register; writes at any other address change nothing.
- R4: A write to register 0x00 sets the read-port address to (value << 2) | 3, only while the card is in isolation (code 2); in other states it is ignored.
- R5: A wake write (register 0x03) whose value equals the card select number pulses `index_clr` for one cycle; from sleep it moves the card to isolation when the value is 0 and to configure (code 3) otherwise.
- R6: A wake write whose value differs from the card select number sends a card in isolation or configure to sleep and leaves a sleeping card asleep.
- R7: A write to register 0x06 in isolation stores the card select number and moves the card to configure; an `isolation_lost` pulse in isolation with no data write in the same cycle moves the card to sleep.
- R8: Register 0x02 is the control register, acted on only outside wait-for-key: bit 0 clears the activate bit of every logical device, bit 2 clears the card select number, bit 1 returns the card to wait-for-key.
- R9: In configure, register 0x07 selects the logical device when the value is below the device count (larger values are ignored); register 0x30 writes the selected device's activate bit keeping only data bit 0, and register 0x31 its range check field keeping only bits 1:0.
- R10: In configure, registers 0x40 and up (as many as the configuration depth) hold per-device configuration bytes of the selected device.
- R11: A read returns, one cycle after the strobe with `rd_valid`, 0x01 for register 0x05 and the stored value for registers 0x06, 0x07, 0x30, 0x31 and 0x40 and up; it returns 0xFF when the card is not in configure, when the read address is not the read-port address, or for any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per bus write |
| io_rd | input | 1 | I/O read strobe, one cycle per bus read |
| io_addr | input | 12 | I/O address of the current bus cycle |
| io_wdata | input | 8 | Write data |
| key_ok | input | 1 | Pulse: unlock key recognised |
| isolation_lost | input | 1 | Pulse: card lost a serial isolation round |
| rd_valid | output | 1 | Read response beat, one cycle after `io_rd` |
| rd_data | output | 8 | Read response byte, valid with `rd_valid` |
| card_state | output | 2 | 0 wait-for-key, 1 sleep, 2 isolation, 3 configure |
| csn | output | 8 | Card select number |
| ldn | output | 2 | Selected logical device |
| read_port | output | 10 | Read-data-port address |
| index_clr | output | 1 | Pulse: reset resource-data and isolation indices |
| dev_active | output | 4 | Activate bit per logical device |
| dev_range | output | 8 | Range check field per device, device d at bits 2d+1:2d |

## Verification
Every write changes state at the clock edge that samples it, so the bench drives on the falling edge and inspects `card_state`, `csn`, `ldn`, `read_port`, `dev_active`, `dev_range` and `index_clr` at the next falling edge, half a cycle after the update. A read result appears one cycle after its strobe: the driver queues the expected byte when it raises `io_rd`, and a monitor pops and compares on each falling edge where `rd_valid` is high, so a missing, extra or late beat shows up as a mismatch or a leftover queue entry.

// File: rtl/pnp_pkg.sv
package pnp_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_KEY = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_ISOLATE  = 2'd2,
    ST_CONFIG   = 2'd3
  } card_state_e;

  localparam logic [11:0] ADDR_PORT = 12'h279;
  localparam logic [11:0] DATA_PORT = 12'hA79;

  localparam logic [7:0] REG_RDPORT   = 8'h00;
  localparam logic [7:0] REG_CTL      = 8'h02;
  localparam logic [7:0] REG_WAKE     = 8'h03;
  localparam logic [7:0] REG_STATUS   = 8'h05;
  localparam logic [7:0] REG_CSN      = 8'h06;
  localparam logic [7:0] REG_LDN      = 8'h07;
  localparam logic [7:0] REG_ACT      = 8'h30;
  localparam logic [7:0] REG_RANGE    = 8'h31;
  localparam logic [7:0] REG_CFG_BASE = 8'h40;

  localparam int CTL_RESET  = 0;
  localparam int CTL_WFK    = 1;
  localparam int CTL_RSTCSN = 2;

endpackage

// File: rtl/pnp_bus_decode.sv
module pnp_bus_decode
  import pnp_pkg::*;
#(
  parameter int AW = 12,
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [AW-1:0] io_addr,
  input  logic [7:0]    io_wdata,
  input  logic [PW-1:0] read_port,
  output logic [7:0]    reg_sel,
  output logic          data_we,
  output logic          rd_hit
);

  logic addr_we;

  assign addr_we = io_wr && (io_addr == AW'(ADDR_PORT));
  assign data_we = io_wr && (io_addr == AW'(DATA_PORT));
  assign rd_hit  = io_rd && (io_addr == AW'(read_port));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_sel <= 8'h00;
    else if (addr_we) reg_sel <= io_wdata;
  end

  // R3
  latch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_sel) |-> $past(io_wr && (io_addr == AW'(ADDR_PORT))));

endmodule

// File: rtl/pnp_card_fsm.sv
module pnp_card_fsm
  import pnp_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int LDW  = $clog2(NDEV),
  parameter int PW   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_ok,
  input  logic          isolation_lost,
  input  logic          data_we,
  input  logic [7:0]    reg_sel,
  input  logic [7:0]    wdata,
  output card_state_e   state,
  output logic [7:0]    csn,
  output logic [LDW-1:0] ldn,
  output logic [PW-1:0] read_port,
  output logic          index_clr,
  output logic          clr_act,
  output logic          dev_we
);

  logic awake;

  assign awake   = (state != ST_WAIT_KEY);
  assign clr_act = data_we && awake && (reg_sel == REG_CTL) && wdata[CTL_RESET];
  assign dev_we  = data_we && (state == ST_CONFIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_WAIT_KEY;
      csn       <= 8'h00;
      ldn       <= '0;
      read_port <= '0;
      index_clr <= 1'b0;
    end else begin
      index_clr <= 1'b0;
      if (!awake) begin
        if (key_ok) state <= ST_SLEEP;
      end else if (data_we) begin
        case (reg_sel)
          REG_RDPORT: begin
            if (state == ST_ISOLATE) read_port <= PW'({wdata, 2'b11});
          end
          REG_CTL: begin
            if (wdata[CTL_RSTCSN]) csn <= 8'h00;
            if (wdata[CTL_WFK]) state <= ST_WAIT_KEY;
          end
          REG_WAKE: begin
            if (wdata != csn) begin
              if (state == ST_ISOLATE || state == ST_CONFIG) state <= ST_SLEEP;
            end else begin
              index_clr <= 1'b1;
              if (state == ST_SLEEP)
                state <= (wdata == 8'h00) ? ST_ISOLATE : ST_CONFIG;
            end
          end
          REG_CSN: begin
            if (state == ST_ISOLATE) begin
              csn   <= wdata;
              state <= ST_CONFIG;
            end
          end
          REG_LDN: begin
            if (state == ST_CONFIG && int'(wdata) < NDEV) ldn <= wdata[LDW-1:0];
          end
          default: ;
        endcase
      end else if (isolation_lost && state == ST_ISOLATE) begin
        state <= ST_SLEEP;
      end
    end
  end

  // R2
  wfk_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_KEY) |=> (state == ST_WAIT_KEY || state == ST_SLEEP));

  // R7
  csn_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(csn) |-> ($past(state) == ST_ISOLATE || csn == 8'h00));

  // R4
  rdport_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(read_port) |-> ($past(state) == ST_ISOLATE));

  // R5
  idx_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    index_clr |-> (state != ST_WAIT_KEY));

endmodule

// File: rtl/pnp_dev_regs.sv
module pnp_dev_regs
  import pnp_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int NCFG = 8,
  parameter int LDW  = $clog2(NDEV)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            clr_act,
  input  logic [7:0]      reg_sel,
  input  logic [7:0]      wdata,
  input  logic [LDW-1:0]  ldn,
  output logic [NDEV-1:0] act,
  output logic [2*NDEV-1:0] rng,
  output logic [7:0]      rdata
);

  localparam int CIW = (NCFG > 1) ? $clog2(NCFG) : 1;

  logic [7:0]     cfg_off;
  logic           cfg_hit;
  logic [CIW-1:0] cidx;
  logic [7:0]     dev_rd [NDEV];

  assign cfg_off = reg_sel - REG_CFG_BASE;
  assign cfg_hit = (reg_sel >= REG_CFG_BASE) && (cfg_off < 8'(NCFG));
  assign cidx    = cfg_off[CIW-1:0];
  assign rdata   = dev_rd[ldn];

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    logic       sel;
    logic       a_q;
    logic [1:0] r_q;
    logic [7:0] c_q [NCFG];
    logic [7:0] rd_l;

    assign sel          = wr_en && (ldn == LDW'(d));
    assign act[d]       = a_q;
    assign rng[2*d +: 2] = r_q;
    assign dev_rd[d]    = rd_l;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q <= 1'b0;
        r_q <= 2'b00;
        for (int i = 0; i < NCFG; i++) c_q[i] <= 8'h00;
      end else begin
        if (clr_act) a_q <= 1'b0;
        else if (sel && reg_sel == REG_ACT) a_q <= wdata[0];
        if (sel && reg_sel == REG_RANGE) r_q <= wdata[1:0];
        if (sel && cfg_hit) c_q[cidx] <= wdata;
      end
    end

    always_comb begin
      if (reg_sel == REG_ACT) rd_l = {7'b0, a_q};
      else if (reg_sel == REG_RANGE) rd_l = {6'b0, r_q};
      else if (cfg_hit) rd_l = c_q[cidx];
      else rd_l = 8'hFF;
    end
  end

  // R9
  act_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act) |-> $past(wr_en || clr_act));

  // R9
  rng_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rng) |-> $past(wr_en));

endmodule

// File: rtl/pnp_card_ctrl.sv
module pnp_card_ctrl
  import pnp_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int NCFG = 8,
  parameter int AW   = 12,
  parameter int PW   = 10,
  parameter int LDW  = $clog2(NDEV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [AW-1:0]     io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              key_ok,
  input  logic              isolation_lost,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic [1:0]        card_state,
  output logic [7:0]        csn,
  output logic [LDW-1:0]    ldn,
  output logic [PW-1:0]     read_port,
  output logic              index_clr,
  output logic [NDEV-1:0]   dev_active,
  output logic [2*NDEV-1:0] dev_range
);

  logic [7:0]  reg_sel;
  logic        data_we;
  logic        rd_hit;
  logic        clr_act;
  logic        dev_we;
  logic [7:0]  dev_rdata;
  logic [7:0]  rd_mux;
  card_state_e state;

  assign card_state = state;

  pnp_bus_decode #(.AW(AW), .PW(PW)) u_dec (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .read_port(read_port),
    .reg_sel(reg_sel), .data_we(data_we), .rd_hit(rd_hit)
  );

  pnp_card_fsm #(.NDEV(NDEV), .LDW(LDW), .PW(PW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .key_ok(key_ok), .isolation_lost(isolation_lost),
    .data_we(data_we), .reg_sel(reg_sel), .wdata(io_wdata),
    .state(state), .csn(csn), .ldn(ldn), .read_port(read_port),
    .index_clr(index_clr), .clr_act(clr_act), .dev_we(dev_we)
  );

  pnp_dev_regs #(.NDEV(NDEV), .NCFG(NCFG), .LDW(LDW)) u_dev (
    .clk(clk), .rst_n(rst_n), .wr_en(dev_we), .clr_act(clr_act),
    .reg_sel(reg_sel), .wdata(io_wdata), .ldn(ldn),
    .act(dev_active), .rng(dev_range), .rdata(dev_rdata)
  );

  always_comb begin
    rd_mux = 8'hFF;
    if (rd_hit && state == ST_CONFIG) begin
      case (reg_sel)
        REG_STATUS: rd_mux = 8'h01;
        REG_CSN:    rd_mux = csn;
        REG_LDN:    rd_mux = 8'(ldn);
        default:    rd_mux = dev_rdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'hFF;
    end else begin
      rd_valid <= io_rd;
      if (io_rd) rd_data <= rd_mux;
    end
  end

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(state) != ST_CONFIG) |-> (rd_data == 8'hFF));

  // R11
  rd_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(io_rd));

endmodule

// File: tb/tb_pnp_card_ctrl.sv
module tb_pnp_card_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [11:0] io_addr = 12'h000;
  logic [7:0]  io_wdata = 8'h00;
  logic        key_ok = 1'b0;
  logic        isolation_lost = 1'b0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [1:0]  card_state;
  logic [7:0]  csn;
  logic [1:0]  ldn;
  logic [9:0]  read_port;
  logic        index_clr;
  logic [3:0]  dev_active;
  logic [7:0]  dev_range;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  localparam logic [9:0] RPORT = 10'h2F3;

  always #10 clk = ~clk;

  pnp_card_ctrl dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .key_ok(key_ok), .isolation_lost(isolation_lost),
    .rd_valid(rd_valid), .rd_data(rd_data), .card_state(card_state), .csn(csn),
    .ldn(ldn), .read_port(read_port), .index_clr(index_clr),
    .dev_active(dev_active), .dev_range(dev_range)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [7:0] v);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = v;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic wr_reg(logic [7:0] r, logic [7:0] v);
    bus_wr(12'h279, r);
    bus_wr(12'hA79, v);
  endtask

  task automatic rd_reg(logic [7:0] r, logic [11:0] port, logic [7:0] exp, string tag);
    bus_wr(12'h279, r);
    @(negedge clk);
    io_rd = 1'b1; io_addr = port;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic pulse_key();
    @(negedge clk); key_ok = 1'b1;
    @(negedge clk); key_ok = 1'b0;
  endtask

  // monitor: pops expected read bytes as the design produces them
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R11 unexpected beat actual=0x%0h expected=none", rd_data);
      end else begin
        check(tag_q.pop_front(), int'(rd_data), int'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 state", card_state, 0);
    check("R1 csn", csn, 0);
    check("R1 ldn", ldn, 0);
    check("R1 read_port", read_port, 0);
    check("R1 active", dev_active, 0);
    check("R1 range", dev_range, 0);

    // R2 writes ignored in wait-for-key
    wr_reg(8'h03, 8'h00);
    check("R2 wake ignored in wfk", card_state, 0);
    wr_reg(8'h06, 8'h09);
    check("R2 csn ignored in wfk", csn, 0);
    pulse_key();
    check("R2 key to sleep", card_state, 1);
    pulse_key();
    check("R2 key ignored in sleep", card_state, 1);

    // R3 write at a foreign address does nothing
    bus_wr(12'h279, 8'h03);
    bus_wr(12'h123, 8'h00);
    check("R3 foreign write", card_state, 1);

    // R4 set-read-port ignored outside isolation
    wr_reg(8'h00, 8'hBC);
    check("R4 rdport ignored in sleep", read_port, 0);

    // R5 matching wake 0 from sleep -> isolation, index_clr pulse
    wr_reg(8'h03, 8'h00);
    check("R5 wake0 to isolation", card_state, 2);
    check("R5 index_clr pulse", index_clr, 1);
    @(negedge clk);
    check("R5 index_clr one cycle", index_clr, 0);

    wr_reg(8'h00, 8'hBC);
    check("R4 rdport in isolation", read_port, 10'h2F3);
    rd_reg(8'h05, {2'b00, RPORT}, 8'hFF, "R11 read outside configure");

    // R7 csn write in isolation
    wr_reg(8'h06, 8'h05);
    check("R7 csn stored", csn, 5);
    check("R7 to configure", card_state, 3);

    // R11 reads in configure
    rd_reg(8'h05, {2'b00, RPORT}, 8'h01, "R11 status");
    rd_reg(8'h06, {2'b00, RPORT}, 8'h05, "R11 csn read");
    rd_reg(8'h06, 12'h2F7, 8'hFF, "R11 wrong port");

    // R9 ldn select and masking
    wr_reg(8'h07, 8'h02);
    check("R9 ldn select", ldn, 2);
    wr_reg(8'h07, 8'h09);
    check("R9 ldn out of range ignored", ldn, 2);
    rd_reg(8'h07, {2'b00, RPORT}, 8'h02, "R11 ldn read");
    wr_reg(8'h30, 8'hFF);
    check("R9 activate bit0 only", dev_active, 4'b0100);
    wr_reg(8'h31, 8'hFF);
    check("R9 range bits1:0", dev_range, 8'h30);
    rd_reg(8'h30, {2'b00, RPORT}, 8'h01, "R9 activate read");
    rd_reg(8'h31, {2'b00, RPORT}, 8'h03, "R9 range read");

    // R10 per-device configuration bytes
    wr_reg(8'h41, 8'hA5);
    wr_reg(8'h07, 8'h01);
    wr_reg(8'h41, 8'h3C);
    rd_reg(8'h41, {2'b00, RPORT}, 8'h3C, "R10 dev1 cfg");
    wr_reg(8'h07, 8'h02);
    rd_reg(8'h41, {2'b00, RPORT}, 8'hA5, "R10 dev2 cfg");
    rd_reg(8'h47, {2'b00, RPORT}, 8'h00, "R10 dev2 cfg untouched");
    rd_reg(8'h20, {2'b00, RPORT}, 8'hFF, "R11 unmapped reg");

    // R6 non-matching wake
    wr_reg(8'h03, 8'h07);
    check("R6 configure to sleep", card_state, 1);
    rd_reg(8'h06, {2'b00, RPORT}, 8'hFF, "R11 sleep read");
    wr_reg(8'h03, 8'h07);
    check("R6 sleep stays", card_state, 1);

    // R5 matching nonzero wake -> configure
    wr_reg(8'h03, 8'h05);
    check("R5 wake csn to configure", card_state, 3);

    // R8 config-control
    wr_reg(8'h02, 8'h01);
    check("R8 reset clears activate", dev_active, 0);
    check("R8 reset keeps csn", csn, 5);
    wr_reg(8'h30, 8'h01);
    check("R9 reactivate", dev_active, 4'b0100);
    wr_reg(8'h02, 8'h02);
    check("R8 to wait-for-key", card_state, 0);
    wr_reg(8'h02, 8'h05);
    check("R8 ignored in wfk act", dev_active, 4'b0100);
    check("R8 ignored in wfk csn", csn, 5);
    pulse_key();
    wr_reg(8'h03, 8'h05);
    check("R5 rewake", card_state, 3);
    wr_reg(8'h02, 8'h04);
    check("R8 reset csn", csn, 0);
    check("R8 reset csn keeps state", card_state, 3);

    // R7 isolation lost
    wr_reg(8'h02, 8'h02);
    pulse_key();
    wr_reg(8'h03, 8'h00);
    check("R7 enter isolation", card_state, 2);
    @(negedge clk); isolation_lost = 1'b1;
    @(negedge clk); isolation_lost = 1'b0;
    check("R7 isolation lost to sleep", card_state, 1);

    repeat (3) @(negedge clk);
    check("R11 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule